// File: doc/BRIEF.md
# SPI-3 Transmit Word Formatter

This block turns words taken from a transmit buffer into cycles on an SPI-3 style transmit bus. Each buffered word is 40 bits wide. The low 32 bits carry data. Bit 39 is a marker that tells an in-band port address apart from ordinary payload. A payload word goes onto the data bus unchanged. A port-address word raises the start-of-transfer output for its cycle. Before it is sent, the two data bits just above its port field are cleared, so the receiver never sees stray bits beside the port number.

One parity bit goes out with every bus word, idle cycles included. It covers the 32 data bits exactly as they are driven. Parity can be set to even or odd. The configuration inputs (port count and parity sense) are sampled in the same cycle as the word they apply to, so they can change from one word to the next. All outputs are registered, which gives a latency of one clock. The enable for an external status sequencer is held inactive.

Top module: `spi3TxWordFormatter`

## Requirements
- R1: While reset is asserted and after reset until the first word, txData is 0, txStart is 0 and txParity is 0 (with parityOdd low).
- R2: A word presented with wordValid high and bit 39 high makes txStart high in the following cycle.
- R3: txStart is low in the cycle after a payload word (bit 39 low) and in the cycle after a cycle with wordValid low.
- R4: A payload word appears on txData one cycle later with bits [31:0] unchanged.
- R5: For a port word, the port field width is P = portCfg+1 (portCfg 0,1,2,3 gives 2,4,8,16 ports). On txData, bits [P+1:P] are cleared and every other bit of [31:0] is passed through.
- R6: The cycle after wordValid is low, txData is 0.
- R7: With parityOdd low, txParity equals the XOR of the 32 bits of txData driven in the same cycle.
- R8: With parityOdd high, txParity is the inverse of the XOR of txData, so that txData and txParity together hold an odd number of ones.
- R9: Bits [38:32] of wordIn have no effect on any output.
- R10: extStatusEn is 0 at all times.
- R11: portCfg and parityOdd take effect per word. Each output cycle reflects the values present with the word that produced it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wordIn | input | 40 | Buffer word: data in [31:0], port marker in bit 39 |
| wordValid | input | 1 | wordIn holds a word to send this cycle |
| portCfg | input | 2 | Port field width minus one (0..3 gives 2..16 ports) |
| parityOdd | input | 1 | 1 selects odd parity, 0 selects even |
| txData | output | 32 | Transmit data bus |
| txStart | output | 1 | Start-of-transfer, high while a port number is driven |
| txParity | output | 1 | Parity over txData |
| extStatusEn | output | 1 | External status sequencer enable, held at 0 |

## Verification
The hardest case to reach is a port word whose data already has ones in the cleared pair at every port-field position. This must be combined with back-to-back changes of portCfg and parity sense, so that a stale setting would show up in the very next output. The stimulus sweeps every portCfg, both parity senses and both marker values over a set of data patterns that includes all-ones and pseudo-random words. It changes the configuration on every word without idle gaps. Separate pairs of words send identical data with different bits [38:32] to expose any leakage from the unused bits.

// File: rtl/txFmtPkg.sv
package txFmtPkg;
  localparam int DATA_W   = 32;
  localparam int WORD_W   = 40;
  localparam int MARK_BIT = 39;
  localparam int CFG_W    = 2;
  localparam int NUM_CFG  = 1 << CFG_W;
  localparam int CLR_W    = 2;

  typedef struct packed {
    logic sendPort;
    logic sendPayload;
    logic idle;
  } fmtCtlT;
endpackage

// File: rtl/txFmtCtrl.sv
module txFmtCtrl
  import txFmtPkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   wordValid,
  input  logic   markBit,
  output fmtCtlT ctl,
  output logic   txStart
);
  logic startQ;

  always_comb begin
    ctl             = '0;
    ctl.sendPort    = wordValid && markBit;
    ctl.sendPayload = wordValid && !markBit;
    ctl.idle        = !wordValid;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) startQ <= 1'b0;
    else       startQ <= ctl.sendPort;
  end

  assign txStart = startQ;

  AST_CTL_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $countones(ctl) == 1); // R3
  AST_START_ON_PORT: assert property (@(posedge clk) disable iff (!rstN)
    (wordValid && markBit) |=> txStart); // R2
  AST_NO_START_OTHERWISE: assert property (@(posedge clk) disable iff (!rstN)
    !(wordValid && markBit) |=> !txStart); // R3
endmodule

// File: rtl/txFmtDatapath.sv
module txFmtDatapath
  import txFmtPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  fmtCtlT            ctl,
  input  logic [DATA_W-1:0] wordData,
  input  logic [CFG_W-1:0]  portCfg,
  input  logic              parityOdd,
  output logic [DATA_W-1:0] txData,
  output logic              txParity
);
  logic [DATA_W-1:0] clrMask [NUM_CFG];
  logic [DATA_W-1:0] dataD;
  logic [DATA_W-1:0] dataQ;
  logic              parityD;
  logic              parityQ;

  for (genvar c = 0; c < NUM_CFG; c++) begin : g_mask
    localparam int LOW_BIT = c + 1;
    assign clrMask[c] = ~(DATA_W'((1 << CLR_W) - 1) << LOW_BIT);
  end

  always_comb begin
    dataD = '0;
    if (ctl.sendPort)         dataD = wordData & clrMask[portCfg];
    else if (ctl.sendPayload) dataD = wordData;
    parityD = (^dataD) ^ parityOdd;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataQ   <= '0;
      parityQ <= 1'b0;
    end else begin
      dataQ   <= dataD;
      parityQ <= parityD;
    end
  end

  assign txData   = dataQ;
  assign txParity = parityQ;

  AST_PARITY_SENSE: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((^{txData, txParity}) == $past(parityOdd))); // R7
  AST_PORT_PAIR_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    ctl.sendPort |=> (((txData >> (32'($past(portCfg)) + 1)) & DATA_W'(3)) == '0)); // R5
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    ctl.idle |=> (txData == '0)); // R6
endmodule

// File: rtl/spi3TxWordFormatter.sv
module spi3TxWordFormatter
  import txFmtPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [WORD_W-1:0] wordIn,
  input  logic              wordValid,
  input  logic [CFG_W-1:0]  portCfg,
  input  logic              parityOdd,
  output logic [DATA_W-1:0] txData,
  output logic              txStart,
  output logic              txParity,
  output logic              extStatusEn
);
  fmtCtlT ctl;

  txFmtCtrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .wordValid (wordValid),
    .markBit   (wordIn[MARK_BIT]),
    .ctl       (ctl),
    .txStart   (txStart)
  );

  txFmtDatapath u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .wordData  (wordIn[DATA_W-1:0]),
    .portCfg   (portCfg),
    .parityOdd (parityOdd),
    .txData    (txData),
    .txParity  (txParity)
  );

  assign extStatusEn = 1'b0;

  AST_PAYLOAD_PASS: assert property (@(posedge clk) disable iff (!rstN)
    (wordValid && !wordIn[MARK_BIT]) |=> (txData == $past(wordIn[DATA_W-1:0]))); // R4
  AST_SPARE_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (wordValid && $past(wordValid) && $stable(wordIn[DATA_W-1:0]) && $stable(wordIn[MARK_BIT])
     && $stable(portCfg) && $stable(parityOdd) && !$stable(wordIn[MARK_BIT-1:DATA_W]))
    |=> ($stable(txData) && $stable(txParity) && $stable(txStart))); // R9
endmodule

// File: tb/sim_spi3TxWordFormatter.sv
module sim_spi3TxWordFormatter;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [39:0] wordIn = '0;
  logic        wordValid = 1'b0;
  logic [1:0]  portCfg = '0;
  logic        parityOdd = 1'b0;
  logic [31:0] txData;
  logic        txStart;
  logic        txParity;
  logic        extStatusEn;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [31:0] rng = 32'h1234_5678;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi3TxWordFormatter u0 (
    .clk(clk), .rstN(rstN), .wordIn(wordIn), .wordValid(wordValid),
    .portCfg(portCfg), .parityOdd(parityOdd), .txData(txData),
    .txStart(txStart), .txParity(txParity), .extStatusEn(extStatusEn)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] nextRand();
    rng = rng ^ (rng << 13);
    rng = rng ^ (rng >> 17);
    rng = rng ^ (rng << 5);
    return rng;
  endfunction

  // Drive one cycle at the falling edge, check outputs at the next falling edge.
  task automatic step(input logic valid, input logic mark, input logic [6:0] spare,
                      input logic [31:0] d, input logic [1:0] cfg, input logic odd, input string req);
    logic [31:0] expD;
    wordValid = valid;
    wordIn    = {mark, spare, d};
    portCfg   = cfg;
    parityOdd = odd;
    if (!valid)    expD = 32'h0;
    else if (mark) expD = d & ~(32'h3 << (int'(cfg) + 1));
    else           expD = d;
    @(negedge clk);
    chk(req, "txData", txData, expD);
    chk(valid && mark ? "R2" : "R3", "txStart", 32'(txStart), 32'(valid && mark));
    chk(odd ? "R8" : "R7", "txParity", 32'(txParity), 32'((^expD) ^ odd));
    chk("R10", "extStatusEn", 32'(extStatusEn), 32'h0);
  endtask

  initial begin
    @(negedge clk);
    chk("R1", "txData in reset", txData, 32'h0);
    chk("R1", "txStart in reset", 32'(txStart), 32'h0);
    chk("R1", "txParity in reset", 32'(txParity), 32'h0);
    @(negedge clk);
    rstN = 1'b1;
    chk("R1", "txData after reset", txData, 32'h0);
    chk("R1", "txStart after reset", 32'(txStart), 32'h0);

    // Idle cycles with both parity senses (R6)
    for (int p = 0; p < 2; p++) step(1'b0, 1'b1, 7'h7f, 32'hffff_ffff, 2'd3, p[0], "R6");

    // Main sweep: every config, parity sense and marker, back to back (R4, R5, R11)
    for (int c = 0; c < 4; c++)
      for (int p = 0; p < 2; p++)
        for (int m = 0; m < 2; m++)
          for (int i = 0; i < 12; i++) begin
            logic [31:0] d;
            if (i == 0)      d = 32'h0;
            else if (i == 1) d = 32'hffff_ffff;
            else if (i == 2) d = 32'h3 << (c + 1);
            else if (i == 3) d = 32'h1f;
            else             d = nextRand();
            step(1'b1, m[0], 7'(i * 13), d, 2'(c), p[0], m[0] ? "R5" : "R4");
          end

    // Per-word configuration changes with no gap (R11)
    for (int i = 0; i < 16; i++)
      step(1'b1, 1'b1, 7'h00, 32'hffff_ffff, 2'(i % 4), 1'((i / 4) % 2), "R11");

    // Spare bits differ, everything else equal: outputs must match (R9)
    for (int i = 0; i < 8; i++) begin
      logic [31:0] d = nextRand();
      logic [31:0] d1;
      logic s1;
      logic p1;
      step(1'b1, 1'(i % 2), 7'h00, d, 2'(i % 4), 1'(i / 4), "R9");
      d1 = txData; s1 = txStart; p1 = txParity;
      step(1'b1, 1'(i % 2), 7'h7f, d, 2'(i % 4), 1'(i / 4), "R9");
      chk("R9", "txData vs spare", txData, d1);
      chk("R9", "txStart vs spare", 32'(txStart), 32'(s1));
      chk("R9", "txParity vs spare", 32'(txParity), 32'(p1));
    end

    // Return to idle after traffic (R6)
    step(1'b0, 1'b0, 7'h55, 32'hdead_beef, 2'd1, 1'b1, "R6");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule